// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Unit

This block takes writes to a 64-bit interrupt command register and turns each completed command into actions for a group of processor targets. Fixed and non-maskable commands are spread over one or more targets, picked by a destination shorthand. INIT and startup commands drive a small boot sequencer kept for every target. A startup command that takes effect raises a start strobe. The strobe carries the target index and a start address built from the command vector.

The register is written in two halves. With legacy addressing, a write to the high half only stores it. A write to the low half then sends the command, using the stored high half. With extended addressing, a low-half write carries the whole 64-bit command, and writes to the high half are dropped. Every write carries the index of the processor that issued it. Only processor 0, the boot processor, may move other targets through their boot sequence. A command the block does not act on raises a one-cycle `unhandled` pulse.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, target 0 is running and every other target is in its initial boot state, so `tgt_run` equals 1. All action outputs are low.
- R2: The command fields are: vector in bits 7:0, delivery mode in bits 10:8, level in bit 14 (1 = assert), shorthand in bits 19:18. A fixed command (mode 000) with the named shorthand (00) sets exactly the `irq_req` bit of the destination. It also puts bits 7:0 on `irq_vec`. This happens in the cycle after the low-half write.
- R3: An NMI command (mode 100) sets the selected targets' bits in `nmi_req` and leaves `irq_req` at zero.
- R4: The shorthand for fixed and NMI commands selects as follows. 01 selects the writer only. 10 selects every running target. 11 selects every running target except the writer. With 00, a destination not below N_TGT selects nothing, and `unhandled` stays low.
- R5: In legacy mode the destination is bits 63:56 of the stored high half. In extended mode it is bits 63:32 of the low-half write data. A high-half write in extended mode does not change the stored high half.
- R6: An INIT command (mode 101) with level 0 changes no boot state and does not raise `unhandled`.
- R7: An asserted INIT from processor 0 to a destination from 1 to N_TGT-1 moves that target from its initial state to waiting for startup. A target in any other state keeps its state.
- R8: A startup command (mode 110) from processor 0 to a waiting target makes that target running and sets its `tgt_run` bit. In the next cycle it also pulses `start_vld` once, with `start_tgt` equal to the destination and `start_addr` equal to the vector shifted left by 12.
- R9: A startup command to a target that is not waiting raises no strobe and changes no state.
- R10: The following commands pulse `unhandled` for one cycle and take no other action: any other delivery mode, and INIT (asserted) or startup commands that come from a nonzero writer, name destination 0, or name a destination not below N_TGT.
- R11: Every action output is a single-cycle pulse. Nothing is raised in a cycle that follows no low-half write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_mode | input | 1 | 1 = extended addressing, 0 = legacy |
| wr_lo | input | 1 | Write strobe for the low half (sends the command) |
| wr_hi | input | 1 | Write strobe for the high half |
| wr_data | input | 64 | Write data; bits 31:0 for a legacy write, all 64 bits for an extended low-half write |
| wr_src | input | TIDX_W | Index of the processor issuing the write |
| irq_req | output | N_TGT | One bit per target: fixed interrupt request pulse |
| irq_vec | output | 8 | Vector that goes with `irq_req` |
| nmi_req | output | N_TGT | One bit per target: NMI pulse |
| start_vld | output | 1 | Start strobe |
| start_tgt | output | TIDX_W | Target index for the start strobe |
| start_addr | output | 8+PAGE_SH | Start address (vector << PAGE_SH) |
| unhandled | output | 1 | Pulse for a command the block does not act on |
| tgt_run | output | N_TGT | Running state of each target |

## Verification
A boot sequencer left in the wrong state shows up at the ports in one of two ways. A target stuck waiting never raises its `tgt_run` bit, and no strobe appears in the cycle after its startup command. A target that moves too early raises a strobe for a startup that should have been dropped. Because `tgt_run` feeds the all-running shorthands, a wrong running bit also changes `irq_req` in the cycle after the next broadcast. A stale stored high half sends a named command to the wrong `irq_req` bit one cycle after the low-half write. The directed tasks order their commands so that each of these faults shows up in the first cycle after the command that exposes it.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

   localparam int VEC_W = 8;
   localparam int CMD_W = 64;
   localparam int DST_W = 32;

   localparam int VEC_LSB  = 0;
   localparam int MODE_LSB = 8;
   localparam int LVL_BIT  = 14;
   localparam int SH_LSB   = 18;
   localparam int LDST_LSB = 56;
   localparam int XDST_LSB = 32;

   localparam logic [2:0] DM_FIXED = 3'b000;
   localparam logic [2:0] DM_NMI   = 3'b100;
   localparam logic [2:0] DM_INIT  = 3'b101;
   localparam logic [2:0] DM_START = 3'b110;

   typedef enum logic [1:0] {
      BST_INIT = 2'd0,
      BST_WAIT = 2'd1,
      BST_RUN  = 2'd2
   } bst_t;

   typedef enum logic [1:0] {
      SH_NAMED  = 2'd0,
      SH_SELF   = 2'd1,
      SH_ALL    = 2'd2,
      SH_OTHERS = 2'd3
   } sh_t;

   typedef struct packed {
      logic [VEC_W-1:0] vec;
      logic [2:0]       mode;
      logic             lvl;
      sh_t              sh;
      logic [DST_W-1:0] dest;
   } cmd_t;

endpackage

// File: rtl/ipi_cmd_decode.sv
module ipi_cmd_decode
   import ipi_pkg::*;
(
   input  logic [CMD_W-1:0] cmd,
   input  logic             ext_mode,
   output cmd_t             fld
);
   logic [DST_W-1:0] dest_leg;
   logic [DST_W-1:0] dest_ext;
   logic             unused_bits;

   assign dest_leg = DST_W'(cmd[LDST_LSB +: 8]);
   assign dest_ext = cmd[XDST_LSB +: DST_W];

   always_comb begin
      fld.vec  = cmd[VEC_LSB +: VEC_W];
      fld.mode = cmd[MODE_LSB +: 3];
      fld.lvl  = cmd[LVL_BIT];
      fld.sh   = sh_t'(cmd[SH_LSB +: 2]);
      fld.dest = ext_mode ? dest_ext : dest_leg;
   end

   assign unused_bits = ^{cmd[13:11], cmd[17:15], cmd[31:20]};
endmodule

// File: rtl/ipi_dest_sel.sv
module ipi_dest_sel
   import ipi_pkg::*;
#(
   parameter int N_TGT  = 8,
   parameter int TIDX_W = $clog2(N_TGT)
)(
   input  sh_t              sh,
   input  logic [DST_W-1:0] dest,
   input  logic [TIDX_W-1:0] src,
   input  logic [N_TGT-1:0] run,
   output logic [N_TGT-1:0] named_hit,
   output logic [N_TGT-1:0] mask
);
   for (genvar i = 0; i < N_TGT; i++) begin : g_tgt
      logic self_hit;
      assign named_hit[i] = (dest == DST_W'(i));
      assign self_hit     = (src == TIDX_W'(i));
      always_comb begin
         unique case (sh)
            SH_NAMED:  mask[i] = named_hit[i];
            SH_SELF:   mask[i] = self_hit;
            SH_ALL:    mask[i] = run[i];
            SH_OTHERS: mask[i] = run[i] & ~self_hit;
            default:   mask[i] = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/ipi_boot_fsm.sv
module ipi_boot_fsm
   import ipi_pkg::*;
#(
   parameter bit IS_BOOT = 1'b0
)(
   input  logic clk,
   input  logic rst_n,
   input  logic init_go,
   input  logic start_go,
   output bst_t st
);
   localparam bst_t RST_ST = IS_BOOT ? BST_RUN : BST_INIT;

   bst_t st_nx;

   always_comb begin
      st_nx = st;
      unique case (st)
         BST_INIT: if (init_go)  st_nx = BST_WAIT;
         BST_WAIT: if (start_go) st_nx = BST_RUN;
         default:  st_nx = st;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st <= RST_ST;
      else        st <= st_nx;
   end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
   import ipi_pkg::*;
#(
   parameter int N_TGT   = 8,
   parameter int PAGE_SH = 12,
   parameter int TIDX_W  = $clog2(N_TGT),
   parameter int ADDR_W  = VEC_W + PAGE_SH
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_mode,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [CMD_W-1:0]  wr_data,
   input  logic [TIDX_W-1:0] wr_src,
   output logic [N_TGT-1:0]  irq_req,
   output logic [VEC_W-1:0]  irq_vec,
   output logic [N_TGT-1:0]  nmi_req,
   output logic              start_vld,
   output logic [TIDX_W-1:0] start_tgt,
   output logic [ADDR_W-1:0] start_addr,
   output logic              unhandled,
   output logic [N_TGT-1:0]  tgt_run
);
   if (N_TGT < 2 || N_TGT > 256) begin : g_bad_ntgt
      $error("ipi_cmd_unit: N_TGT must lie in 2..256");
   end
   if (PAGE_SH < 1 || PAGE_SH > 24) begin : g_bad_page
      $error("ipi_cmd_unit: PAGE_SH must lie in 1..24");
   end
   if (TIDX_W < $clog2(N_TGT)) begin : g_bad_tidx
      $error("ipi_cmd_unit: TIDX_W too narrow for N_TGT");
   end

   logic [31:0]      hi_q;
   logic [CMD_W-1:0] cmd64;
   cmd_t             fld;
   logic [N_TGT-1:0] named_hit;
   logic [N_TGT-1:0] sel_mask;
   logic [N_TGT-1:0] wait_mask;
   bst_t             st_arr [N_TGT];

   // stored high half, legacy mode only
   always_ff @(posedge clk) begin
      if (!rst_n)                  hi_q <= '0;
      else if (wr_hi && !ext_mode) hi_q <= wr_data[31:0];
   end

   assign cmd64 = ext_mode ? wr_data : {hi_q, wr_data[31:0]};

   ipi_cmd_decode u_dec (
      .cmd      (cmd64),
      .ext_mode (ext_mode),
      .fld      (fld)
   );

   ipi_dest_sel #(.N_TGT(N_TGT), .TIDX_W(TIDX_W)) u_sel (
      .sh        (fld.sh),
      .dest      (fld.dest),
      .src       (wr_src),
      .run       (tgt_run),
      .named_hit (named_hit),
      .mask      (sel_mask)
   );

   logic is_fixed, is_nmi, is_init, is_start;
   logic dest_ok, from_boot, boot_ok;
   logic init_ign, init_act, start_act, start_ok, handled;

   assign is_fixed  = (fld.mode == DM_FIXED);
   assign is_nmi    = (fld.mode == DM_NMI);
   assign is_init   = (fld.mode == DM_INIT);
   assign is_start  = (fld.mode == DM_START);
   assign dest_ok   = (fld.dest < DST_W'(N_TGT));
   assign from_boot = (wr_src == '0);
   assign boot_ok   = from_boot && dest_ok && (fld.dest != '0);

   assign init_ign  = is_init && !fld.lvl;
   assign init_act  = wr_lo && is_init && fld.lvl && boot_ok;
   assign start_act = wr_lo && is_start && boot_ok;
   assign start_ok  = start_act && |(named_hit & wait_mask);
   assign handled   = is_fixed || is_nmi || init_ign
                      || (is_init && fld.lvl && boot_ok)
                      || (is_start && boot_ok);

   for (genvar i = 0; i < N_TGT; i++) begin : g_boot
      ipi_boot_fsm #(.IS_BOOT(i == 0)) u_fsm (
         .clk      (clk),
         .rst_n    (rst_n),
         .init_go  (init_act  && named_hit[i]),
         .start_go (start_act && named_hit[i]),
         .st       (st_arr[i])
      );
      assign wait_mask[i] = (st_arr[i] == BST_WAIT);
      assign tgt_run[i]   = (st_arr[i] == BST_RUN);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_req    <= '0;
         irq_vec    <= '0;
         nmi_req    <= '0;
         start_vld  <= 1'b0;
         start_tgt  <= '0;
         start_addr <= '0;
         unhandled  <= 1'b0;
      end else begin
         irq_req    <= (wr_lo && is_fixed) ? sel_mask : '0;
         irq_vec    <= (wr_lo && is_fixed) ? fld.vec : '0;
         nmi_req    <= (wr_lo && is_nmi) ? sel_mask : '0;
         start_vld  <= start_ok;
         start_tgt  <= start_ok ? fld.dest[TIDX_W-1:0] : '0;
         start_addr <= start_ok ? {fld.vec, {PAGE_SH{1'b0}}} : '0;
         unhandled  <= wr_lo && !handled;
      end
   end
endmodule

// File: rtl/ipi_cmd_chk.sv
module ipi_cmd_chk #(
   parameter int N_TGT  = 8,
   parameter int TIDX_W = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_lo,
   input logic [N_TGT-1:0]  irq_req,
   input logic [N_TGT-1:0]  nmi_req,
   input logic              start_vld,
   input logic [TIDX_W-1:0] start_tgt,
   input logic              unhandled,
   input logic [N_TGT-1:0]  tgt_run
);
   assert_boot_cpu_runs_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_run[0]);

   assert_one_action_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|irq_req, |nmi_req, start_vld, unhandled}));

   assert_run_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(tgt_run) & ~tgt_run) == '0);

   assert_start_new_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      start_vld |-> (tgt_run[start_tgt] && !(($past(tgt_run) >> start_tgt) & 1'b1)));

   assert_unhandled_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      unhandled |-> (irq_req == '0 && nmi_req == '0 && !start_vld));

   assert_no_write_no_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_lo) |-> (irq_req == '0 && nmi_req == '0 && !start_vld && !unhandled));
endmodule

bind ipi_cmd_unit ipi_cmd_chk #(.N_TGT(N_TGT), .TIDX_W(TIDX_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_lo     (wr_lo),
   .irq_req   (irq_req),
   .nmi_req   (nmi_req),
   .start_vld (start_vld),
   .start_tgt (start_tgt),
   .unhandled (unhandled),
   .tgt_run   (tgt_run)
);

// File: tb/sim_ipi_cmd_unit.sv
module sim_ipi_cmd_unit;
   localparam int N = 8;
   localparam int TW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_mode = 1'b0;
   logic wr_lo = 1'b0;
   logic wr_hi = 1'b0;
   logic [63:0] wr_data = '0;
   logic [TW-1:0] wr_src = '0;
   logic [N-1:0] irq_req, nmi_req, tgt_run;
   logic [7:0] irq_vec;
   logic start_vld, unhandled;
   logic [TW-1:0] start_tgt;
   logic [19:0] start_addr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   ipi_cmd_unit #(.N_TGT(N)) u0 (
      .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wr_data(wr_data), .wr_src(wr_src), .irq_req(irq_req), .irq_vec(irq_vec),
      .nmi_req(nmi_req), .start_vld(start_vld), .start_tgt(start_tgt),
      .start_addr(start_addr), .unhandled(unhandled), .tgt_run(tgt_run)
   );

   localparam logic [2:0] M_FIX = 3'b000, M_LOW = 3'b001, M_NMI = 3'b100,
                          M_INI = 3'b101, M_STA = 3'b110;

   function automatic logic [31:0] cmd(logic [7:0] v, logic [2:0] m, logic l, logic [1:0] s);
      return (32'(s) << 18) | (32'(l) << 14) | (32'(m) << 8) | 32'(v);
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic outs(string req, logic [N-1:0] e_irq, logic [N-1:0] e_nmi,
                       logic e_sv, logic e_unh, logic [N-1:0] e_run);
      chk(req, "irq_req", 32'(irq_req), 32'(e_irq));
      chk(req, "nmi_req", 32'(nmi_req), 32'(e_nmi));
      chk(req, "start_vld", 32'(start_vld), 32'(e_sv));
      chk(req, "unhandled", 32'(unhandled), 32'(e_unh));
      chk(req, "tgt_run", 32'(tgt_run), 32'(e_run));
   endtask

   task automatic put_hi(logic [31:0] v);
      @(negedge clk); wr_hi = 1'b1; wr_data = {32'h0, v};
      @(negedge clk); wr_hi = 1'b0; wr_data = '0;
   endtask

   // outputs are sampled one edge after the low write
   task automatic send(logic [31:0] lo, logic [31:0] hi, logic [TW-1:0] src);
      @(negedge clk); wr_lo = 1'b1; wr_data = {hi, lo}; wr_src = src;
      @(negedge clk); wr_lo = 1'b0; wr_data = '0; wr_src = '0;
   endtask

   task automatic t_reset();
      outs("R1", '0, '0, 0, 0, 8'h01);
   endtask

   task automatic t_fixed_legacy();
      put_hi(32'h0300_0000);
      send(cmd(8'h45, M_FIX, 1, 2'd0), 32'h0, 0);
      outs("R2", 8'h08, '0, 0, 0, 8'h01);
      chk("R2", "irq_vec", 32'(irq_vec), 32'h45);
      @(negedge clk);
      outs("R11", '0, '0, 0, 0, 8'h01);
   endtask

   task automatic t_nmi();
      put_hi(32'h0500_0000);
      send(cmd(8'h02, M_NMI, 1, 2'd0), 32'h0, 0);
      outs("R3", '0, 8'h20, 0, 0, 8'h01);
   endtask

   task automatic t_extended();
      ext_mode = 1'b1;
      put_hi(32'h0100_0000);
      send(cmd(8'h51, M_FIX, 1, 2'd0), 32'd6, 0);
      outs("R5", 8'h40, '0, 0, 0, 8'h01);
      send(cmd(8'h51, M_FIX, 1, 2'd0), 32'd20, 0);
      outs("R4", '0, '0, 0, 0, 8'h01);
      ext_mode = 1'b0;
      send(cmd(8'h52, M_FIX, 1, 2'd0), 32'hFFFF_FFFF, 0);
      outs("R5", 8'h20, '0, 0, 0, 8'h01);
   endtask

   task automatic t_shorthand_boot_only();
      send(cmd(8'h60, M_FIX, 1, 2'd1), 32'h0, 2);
      outs("R4", 8'h04, '0, 0, 0, 8'h01);
      send(cmd(8'h61, M_FIX, 1, 2'd2), 32'h0, 0);
      outs("R4", 8'h01, '0, 0, 0, 8'h01);
      send(cmd(8'h62, M_NMI, 1, 2'd3), 32'h0, 0);
      outs("R4", '0, '0, 0, 0, 8'h01);
   endtask

   task automatic t_init_deassert();
      put_hi(32'h0200_0000);
      send(cmd(8'h00, M_INI, 0, 2'd0), 32'h0, 0);
      outs("R6", '0, '0, 0, 0, 8'h01);
      send(cmd(8'h9A, M_STA, 0, 2'd0), 32'h0, 0);
      outs("R9", '0, '0, 0, 0, 8'h01);
   endtask

   task automatic t_init_nonboot();
      send(cmd(8'h00, M_INI, 1, 2'd0), 32'h0, 1);
      outs("R10", '0, '0, 0, 1, 8'h01);
      @(negedge clk);
      outs("R11", '0, '0, 0, 0, 8'h01);
      send(cmd(8'h9A, M_STA, 0, 2'd0), 32'h0, 0);
      outs("R9", '0, '0, 0, 0, 8'h01);
   endtask

   task automatic t_boot_seq();
      send(cmd(8'h00, M_INI, 1, 2'd0), 32'h0, 0);
      outs("R7", '0, '0, 0, 0, 8'h01);
      send(cmd(8'h9A, M_STA, 0, 2'd0), 32'h0, 0);
      outs("R8", '0, '0, 1, 0, 8'h05);
      chk("R8", "start_tgt", 32'(start_tgt), 32'd2);
      chk("R8", "start_addr", 32'(start_addr), 32'h9A000);
      @(negedge clk);
      outs("R11", '0, '0, 0, 0, 8'h05);
   endtask

   task automatic t_after_boot();
      send(cmd(8'h10, M_STA, 0, 2'd0), 32'h0, 0);
      outs("R9", '0, '0, 0, 0, 8'h05);
      send(cmd(8'h00, M_INI, 1, 2'd0), 32'h0, 0);
      outs("R7", '0, '0, 0, 0, 8'h05);
      send(cmd(8'h70, M_FIX, 1, 2'd3), 32'h0, 0);
      outs("R4", 8'h04, '0, 0, 0, 8'h05);
      send(cmd(8'h71, M_NMI, 1, 2'd2), 32'h0, 0);
      outs("R4", '0, 8'h05, 0, 0, 8'h05);
   endtask

   task automatic t_unhandled();
      send(cmd(8'h33, M_LOW, 1, 2'd0), 32'h0, 0);
      outs("R10", '0, '0, 0, 1, 8'h05);
      put_hi(32'h0000_0000);
      send(cmd(8'h00, M_INI, 1, 2'd0), 32'h0, 0);
      outs("R10", '0, '0, 0, 1, 8'h05);
      ext_mode = 1'b1;
      send(cmd(8'h20, M_STA, 0, 2'd0), 32'd9, 0);
      outs("R10", '0, '0, 0, 1, 8'h05);
      ext_mode = 1'b0;
      put_hi(32'h0300_0000);
      send(cmd(8'h00, M_INI, 1, 2'd0), 32'h0, 0);
      send(cmd(8'h21, M_STA, 0, 2'd0), 32'h0, 4);
      outs("R10", '0, '0, 0, 1, 8'h05);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fixed_legacy();
      t_nmi();
      t_extended();
      t_shorthand_boot_only();
      t_init_deassert();
      t_init_nonboot();
      t_boot_seq();
      t_after_boot();
      t_unhandled();
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(4 * 20000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule